// File: doc/BRIEF.md
# Thermal Protection Sequencer

This block turns three digitised junction-temperature comparator outputs into latched thermal flags and the protective actions they call for. The comparators are ordered low, middle and top. A mode input chooses how the middle and top crossings are read. In normal interpretation, a middle crossing is already a shutdown of the gate drivers and the charge pump. In warning interpretation, a middle crossing is only a second warning, and the drivers are shut down at the top crossing.

A top crossing always switches the supply regulator off. The regulator stays off for a fixed number of ticks and then switches back on. Every switch-off adds one to a 3-bit retry counter. The switch-off that brings the counter to 7 does not start a timed off period. It parks the block in a deep-standby state instead, which only a wake pulse ends. That wake pulse also clears the counter. Flags are cleared by a read-and-clear strobe, and a flag only clears if its comparator is low at that moment.

The sequencer has three named states. RUN means the regulator is on. OFF means the regulator is off for a timed period. DEEP means deep standby has been requested. The transitions are:
- TRIP: RUN to OFF, when the top comparator is high and the counter is below 6.
- PARK: RUN to DEEP, when the top comparator is high and the counter is 6.
- RESUME: OFF to RUN, on the OFF_TICKS-th tick spent in OFF.
- WAKE: DEEP to RUN, on a wake pulse.

Top module: `thermal_guard`

## Requirements
- R1: After reset, all flags, `drv_off`, `reg_off` and `deep_req` are 0, `retry_cnt` is 0 and the state is RUN.
- R2: When `cmp_warn` is 1 at a clock edge, `flag_warn` is 1 after that edge. This holds with `warn_mode` at 0 or at 1.
- R3: With `warn_mode`=0 (normal interpretation), `cmp_mid`=1 sets `flag_mid` and raises `drv_off` on the next edge.
- R4: With `warn_mode`=1 (warning interpretation), `cmp_mid`=1 sets `flag_mid` only. `drv_off` stays 0.
- R5: `cmp_top`=1 in RUN sets `flag_top` and raises `reg_off` on the next edge. `drv_off` is 1 whenever `reg_off` is 1. With `warn_mode`=1, `drv_off` is also 1 while `flag_top` is set.
- R6: Each TRIP adds one to `retry_cnt`. After a TRIP, `reg_off` returns to 0 on the edge that takes the OFF_TICKS-th `tick` pulse, and not before.
- R7: The PARK transition sets `retry_cnt` to 7 (binary 111) and `deep_req` to 1. `reg_off` then stays 1 and the state stays DEEP, whatever the ticks do, until `wake`=1. After that edge `retry_cnt`=0, `deep_req`=0 and `reg_off`=0. The counter never wraps and is cleared by nothing else.
- R8: A flag is cleared on an edge where `clr`=1 only if its own comparator is 0 on that edge. A flag whose comparator is still 1 stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-on) |
| tick | input | 1 | Time-base pulse for the off period |
| cmp_warn | input | 1 | Lowest threshold comparator |
| cmp_mid | input | 1 | Middle threshold comparator |
| cmp_top | input | 1 | Top threshold comparator |
| warn_mode | input | 1 | 0 = normal interpretation, 1 = warning interpretation |
| clr | input | 1 | Read-and-clear strobe for the flags |
| wake | input | 1 | Wake event, ends deep standby |
| flag_warn | output | 1 | Latched low-threshold flag |
| flag_mid | output | 1 | Latched middle-threshold flag |
| flag_top | output | 1 | Latched top-threshold flag |
| drv_off | output | 1 | Gate driver and charge pump disable |
| reg_off | output | 1 | Regulator switch-off |
| retry_cnt | output | 3 | Retry counter value |
| deep_req | output | 1 | Deep-standby request |

## Verification
The bench clears a flag while its comparator is still high. A design with an unconditional clear would drop the flag there. It runs the middle crossing in both interpretations, which catches a design that disables the drivers in warning mode or fails to disable them in normal mode. It counts ticks up to the edge that releases the regulator, so an off period one tick short or one tick long shows up as `reg_off` falling on the wrong edge. It then drives seven trips. A counter that wraps, or a design that leaves DEEP on a tick, would show a counter of 0 or a `deep_req` that falls before the wake pulse.

// File: rtl/thermal_pkg.sv
package thermal_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_OFF  = 2'd1,
        ST_DEEP = 2'd2
    } seq_state_t;

    localparam int NUM_FLAGS = 3;
    localparam int IDX_WARN  = 0;
    localparam int IDX_MID   = 1;
    localparam int IDX_TOP   = 2;
endpackage

// File: rtl/thermal_flag.sv
module thermal_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp,
    input  logic clr,
    output logic flag
);
    // A high comparator sets the flag. The clear strobe only wins when the comparator is low.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (cmp)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    p_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmp |=> flag);
    p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
endmodule

// File: rtl/thermal_seq.sv
module thermal_seq
    import thermal_pkg::*;
#(
    parameter int OFF_TICKS = 4,
    parameter int RETRY_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               cmp_top,
    input  logic               wake,
    output logic               reg_off,
    output logic               deep_req,
    output logic [RETRY_W-1:0] retry_cnt
);
    localparam int TW = (OFF_TICKS < 2) ? 1 : $clog2(OFF_TICKS);
    localparam logic [RETRY_W-1:0] RETRY_MAX  = {RETRY_W{1'b1}};
    localparam logic [RETRY_W-1:0] RETRY_LAST = RETRY_MAX - 1'b1;
    localparam logic [TW-1:0]      OFF_LAST   = TW'(OFF_TICKS - 1);

    seq_state_t         state, state_nx;
    logic [TW-1:0]      off_cnt, off_cnt_nx;
    logic [RETRY_W-1:0] cnt_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_RUN;
            off_cnt   <= '0;
            retry_cnt <= '0;
        end else begin
            state     <= state_nx;
            off_cnt   <= off_cnt_nx;
            retry_cnt <= cnt_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx   = state;
        off_cnt_nx = off_cnt;
        cnt_nx     = retry_cnt;
        unique case (state)
            ST_RUN: begin
                off_cnt_nx = '0;
                if (cmp_top) begin
                    cnt_nx = retry_cnt + 1'b1;
                    if (retry_cnt == RETRY_LAST)
                        state_nx = ST_DEEP;   // PARK
                    else
                        state_nx = ST_OFF;    // TRIP
                end
            end
            ST_OFF: begin
                if (tick) begin
                    if (off_cnt == OFF_LAST) begin
                        state_nx   = ST_RUN;  // RESUME
                        off_cnt_nx = '0;
                    end else begin
                        off_cnt_nx = off_cnt + 1'b1;
                    end
                end
            end
            ST_DEEP: begin
                if (wake) begin
                    state_nx = ST_RUN;        // WAKE
                    cnt_nx   = '0;
                end
            end
            default: state_nx = ST_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        reg_off  = 1'b0;
        deep_req = 1'b0;
        unique case (state)
            ST_RUN:  ;
            ST_OFF:  reg_off = 1'b1;
            ST_DEEP: begin
                reg_off  = 1'b1;
                deep_req = 1'b1;
            end
            default: ;
        endcase
    end

    p_deep_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEEP) |-> (retry_cnt == RETRY_MAX));
    p_deep_stay_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEEP && !wake) |=> (state == ST_DEEP));
    p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_cnt != $past(retry_cnt)) |->
            ((retry_cnt == $past(retry_cnt) + 1'b1) ||
             (retry_cnt == '0 && $past(state) == ST_DEEP && $past(wake))));
    p_off_no_early_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && !tick) |=> (state == ST_OFF));
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard
    import thermal_pkg::*;
#(
    parameter int OFF_TICKS = 4,
    parameter int RETRY_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               cmp_warn,
    input  logic               cmp_mid,
    input  logic               cmp_top,
    input  logic               warn_mode,
    input  logic               clr,
    input  logic               wake,
    output logic               flag_warn,
    output logic               flag_mid,
    output logic               flag_top,
    output logic               drv_off,
    output logic               reg_off,
    output logic [RETRY_W-1:0] retry_cnt,
    output logic               deep_req
);
    logic [NUM_FLAGS-1:0] cmp_vec, flag_vec;

    assign cmp_vec[IDX_WARN] = cmp_warn;
    assign cmp_vec[IDX_MID]  = cmp_mid;
    assign cmp_vec[IDX_TOP]  = cmp_top;

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        thermal_flag u_flag (
            .clk  (clk),
            .rst_n(rst_n),
            .cmp  (cmp_vec[i]),
            .clr  (clr),
            .flag (flag_vec[i])
        );
    end

    assign flag_warn = flag_vec[IDX_WARN];
    assign flag_mid  = flag_vec[IDX_MID];
    assign flag_top  = flag_vec[IDX_TOP];

    thermal_seq #(
        .OFF_TICKS(OFF_TICKS),
        .RETRY_W  (RETRY_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cmp_top  (cmp_top),
        .wake     (wake),
        .reg_off  (reg_off),
        .deep_req (deep_req),
        .retry_cnt(retry_cnt)
    );

    // The mode picks which latched flag shuts the drivers off. A regulator-off state always does.
    assign drv_off = (!warn_mode && flag_vec[IDX_MID])
                   || (warn_mode && flag_vec[IDX_TOP])
                   || reg_off;

    p_mid_drv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!warn_mode && cmp_mid && !$changed(warn_mode)) |=> drv_off);
    p_top_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_top && !reg_off) |=> reg_off);
    p_top_drv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (warn_mode && cmp_top) |=> (drv_off || !warn_mode));
endmodule

// File: tb/sim_thermal_guard.sv
module sim_thermal_guard;
    localparam int OFF_TICKS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 0, cmp_warn = 0, cmp_mid = 0, cmp_top = 0;
    logic warn_mode = 0, clr = 0, wake = 0;
    logic flag_warn, flag_mid, flag_top, drv_off, reg_off, deep_req;
    logic [2:0] retry_cnt;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    thermal_guard #(.OFF_TICKS(OFF_TICKS), .RETRY_W(3)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmp_warn(cmp_warn),
        .cmp_mid(cmp_mid), .cmp_top(cmp_top), .warn_mode(warn_mode),
        .clr(clr), .wake(wake), .flag_warn(flag_warn), .flag_mid(flag_mid),
        .flag_top(flag_top), .drv_off(drv_off), .reg_off(reg_off),
        .retry_cnt(retry_cnt), .deep_req(deep_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clr();
        clr = 1; step(1); clr = 0;
    endtask

    task automatic give_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1; step(1); tick = 0; step(1);
        end
    endtask

    task automatic t_reset();
        chk("R1 flag_warn", flag_warn, 0);
        chk("R1 flag_mid", flag_mid, 0);
        chk("R1 flag_top", flag_top, 0);
        chk("R1 drv_off", drv_off, 0);
        chk("R1 reg_off", reg_off, 0);
        chk("R1 retry_cnt", retry_cnt, 0);
        chk("R1 deep_req", deep_req, 0);
    endtask

    task automatic t_warn();
        warn_mode = 0; cmp_warn = 1; step(1); cmp_warn = 0;
        chk("R2 warn normal", flag_warn, 1);
        chk("R2 drv untouched", drv_off, 0);
        pulse_clr();
        chk("R8 warn cleared", flag_warn, 0);
        warn_mode = 1; cmp_warn = 1; step(1); cmp_warn = 0;
        chk("R2 warn warnmode", flag_warn, 1);
        pulse_clr();
        warn_mode = 0;
    endtask

    task automatic t_mid_normal();
        warn_mode = 0; cmp_mid = 1; step(1);
        chk("R3 flag_mid", flag_mid, 1);
        chk("R3 drv_off", drv_off, 1);
        chk("R3 reg stays on", reg_off, 0);
        pulse_clr();
        chk("R8 mid held while hot", flag_mid, 1);
        cmp_mid = 0; pulse_clr();
        chk("R8 mid cleared", flag_mid, 0);
        chk("R3 drv released", drv_off, 0);
    endtask

    task automatic t_mid_warnmode();
        warn_mode = 1; cmp_mid = 1; step(1); cmp_mid = 0;
        chk("R4 flag_mid", flag_mid, 1);
        chk("R4 drv_off stays 0", drv_off, 0);
        step(2);
        chk("R4 drv_off later", drv_off, 0);
        pulse_clr();
        chk("R8 mid cleared wm", flag_mid, 0);
        warn_mode = 0;
    endtask

    task automatic t_top_retry();
        warn_mode = 1; cmp_top = 1; step(1); cmp_top = 0;
        chk("R5 flag_top", flag_top, 1);
        chk("R5 reg_off", reg_off, 1);
        chk("R5 drv_off", drv_off, 1);
        chk("R6 cnt one", retry_cnt, 1);
        give_ticks(OFF_TICKS - 1);
        chk("R6 still off before last tick", reg_off, 1);
        tick = 1; step(1); tick = 0;
        chk("R6 reg back on", reg_off, 0);
        chk("R5 drv held by flag_top wm", drv_off, 1);
        pulse_clr();
        chk("R8 top cleared", flag_top, 0);
        chk("R5 drv released", drv_off, 0);
        chk("R6 cnt kept", retry_cnt, 1);
        warn_mode = 0;
    endtask

    task automatic t_deep();
        for (int k = 2; k <= 6; k++) begin
            cmp_top = 1; step(1); cmp_top = 0;
            chk("R6 cnt step", retry_cnt, k);
            give_ticks(OFF_TICKS);
            chk("R6 resume", reg_off, 0);
        end
        cmp_top = 1; step(1); cmp_top = 0;
        chk("R7 cnt full", retry_cnt, 7);
        chk("R7 deep_req", deep_req, 1);
        give_ticks(3 * OFF_TICKS);
        chk("R7 deep holds", deep_req, 1);
        chk("R7 reg stays off", reg_off, 1);
        chk("R7 cnt no wrap", retry_cnt, 7);
        wake = 1; step(1); wake = 0;
        chk("R7 wake deep", deep_req, 0);
        chk("R7 wake reg", reg_off, 0);
        chk("R7 wake cnt", retry_cnt, 0);
        pulse_clr();
    endtask

    initial begin
        #(8 * 20000);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1;
        step(1);
        t_reset();
        t_warn();
        t_mid_normal();
        t_mid_warnmode();
        t_top_retry();
        t_deep();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule